// File: doc/BRIEF.md
# Virtual Segment Decoder and Fault Classifier

This block sits in front of a TLB on a 32-bit address path. For each request it decides, from the address, the privilege flag and the error-level flag, whether the address is illegal for the current mode, is translated by a fixed offset rule, or needs the result of a TLB lookup. It then turns the final outcome into either a successful translation or one exception code. On a fault it also gives the new values for the faulting-address, context and entry-high registers.

A request carries the virtual address, a load/store flag, the user-mode and error-level flags, the TLB lookup outcome for that address (hit, valid, dirty, physical address), and the current context and entry-high register values. Requests enter through a valid/ready port. A request is taken when `req_valid` and `req_ready` are both high. The result appears on a registered valid/ready port one cycle later. `req_ready` is high whenever the result register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the result does not change and no new request is taken.

Top module: `vseg_fault_unit`

## Requirements
- R1: In user mode, an address with bit 31 set is a bad address whatever the TLB inputs are: fault with code 5 on a store, code 4 on a load, and the refill flag clear.
- R2: An address below 0x80000000 with the error-level flag set translates to itself, writable, and the TLB inputs have no effect.
- R3: An address below 0x80000000 with the error-level flag clear uses the TLB. On a valid hit that is not a store to a clean page, the physical address is the TLB address and writable equals the TLB dirty bit.
- R4: Addresses 0x80000000 to 0x9FFFFFFF (kernel mode) translate to the address minus 0x80000000, writable, and ignore the TLB inputs.
- R5: Addresses 0xA0000000 to 0xBFFFFFFF (kernel mode) translate to the address minus 0xA0000000, writable, and ignore the TLB inputs.
- R6: Addresses from 0xC0000000 upward (kernel mode) use the TLB with the same rules as R3, R7, R8 and R9.
- R7: On a TLB miss (hit low), the block faults with code 3 on a store and code 2 on a load, with the refill flag set.
- R8: On a TLB hit with the valid bit low, the block faults with code 3 on a store and code 2 on a load, with the refill flag clear.
- R9: A store that hits a valid TLB entry whose dirty bit is low faults with code 1 and the refill flag clear.
- R10: On any fault, the faulting-address output equals the address. The context output equals the context input with bits 22:4 replaced by address bits 31:13. The entry-high output is address bits 31:13 in bits 31:13, zeros in bits 12:8, and entry-high input bits 7:0 in bits 7:0.
- R11: On a fault, the physical address is 0 and writable is 0. On success, the faulting-address output is 0, the context and entry-high outputs equal their inputs, the code is 0 and the refill flag is clear.
- R12: The result of a request taken at a clock edge is presented from that edge. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_user | input | 1 | User-mode flag |
| req_erl | input | 1 | Error-level flag |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_valid | input | 1 | Matching entry half is valid |
| tlb_dirty | input | 1 | Matching entry half is writable |
| tlb_pa | input | 32 | Physical address from the TLB |
| cur_context | input | 32 | Current context register |
| cur_entryhi | input | 32 | Current entry-high register |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_fault | output | 1 | Request faulted |
| rsp_code | output | 5 | Exception code (0 on success) |
| rsp_refill | output | 1 | Fault is a TLB refill |
| rsp_pa | output | 32 | Physical address |
| rsp_writable | output | 1 | Page may be written |
| rsp_badvaddr | output | 32 | New faulting-address register |
| rsp_context | output | 32 | New context register |
| rsp_entryhi | output | 32 | New entry-high register |

## Verification
The hardest case to reach is a result held under back-pressure while a new request with different inputs waits at the input. A correct design keeps the old fault values and leaves the new request untaken. The bench holds `rsp_ready` low after a fault and keeps a conflicting request on the input for several cycles. It checks that `req_ready` stays low and that the code and captured registers do not move. It then releases the port and checks that the waiting request comes out next. The other corner is a store to a clean page, which has to give the modify code and not a TLB store code. The bench sets up that TLB state in both the user segment and the upper kernel segment.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int unsigned AW         = 32;
  localparam int unsigned ASID_W     = 8;
  localparam int unsigned PAGE_SHIFT = 13;
  localparam int unsigned CTX_LO     = 4;
  localparam int unsigned CODE_W     = 5;

  typedef enum logic [1:0] {
    SEG_BAD    = 2'd0,
    SEG_DIRECT = 2'd1,
    SEG_TLB    = 2'd2
  } seg_kind_e;

  localparam logic [CODE_W-1:0] EXC_NONE   = 5'd0;
  localparam logic [CODE_W-1:0] EXC_MODIFY = 5'd1;
  localparam logic [CODE_W-1:0] EXC_TLB_LD = 5'd2;
  localparam logic [CODE_W-1:0] EXC_TLB_ST = 5'd3;
  localparam logic [CODE_W-1:0] EXC_ADR_LD = 5'd4;
  localparam logic [CODE_W-1:0] EXC_ADR_ST = 5'd5;
endpackage

// File: rtl/vseg_decode.sv
module vseg_decode
  import vseg_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          user,
  input  logic          erl,
  output seg_kind_e     kind,
  output logic [AW-1:0] direct_pa
);
  localparam logic [AW-1:0] CACHED_BASE   = 32'h8000_0000;
  localparam logic [AW-1:0] UNCACHED_BASE = 32'hA000_0000;

  always_comb begin
    kind      = SEG_TLB;
    direct_pa = '0;
    if (user && addr[AW-1]) begin
      kind = SEG_BAD;
    end else if (!addr[AW-1]) begin
      if (erl) begin
        kind      = SEG_DIRECT;
        direct_pa = addr;
      end
    end else if (addr[AW-2:AW-3] == 2'b00) begin
      kind      = SEG_DIRECT;
      direct_pa = addr - CACHED_BASE;
    end else if (addr[AW-2:AW-3] == 2'b01) begin
      kind      = SEG_DIRECT;
      direct_pa = addr - UNCACHED_BASE;
    end
  end
endmodule

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
(
  input  seg_kind_e         kind,
  input  logic [AW-1:0]     direct_pa,
  input  logic              store,
  input  logic              hit,
  input  logic              valid,
  input  logic              dirty,
  input  logic [AW-1:0]     tlb_pa,
  output logic              fault,
  output logic [CODE_W-1:0] code,
  output logic              refill,
  output logic [AW-1:0]     pa,
  output logic              writable
);
  always_comb begin
    fault    = 1'b0;
    code     = EXC_NONE;
    refill   = 1'b0;
    pa       = '0;
    writable = 1'b0;
    unique case (kind)
      SEG_BAD: begin
        fault = 1'b1;
        code  = store ? EXC_ADR_ST : EXC_ADR_LD;
      end
      SEG_DIRECT: begin
        pa       = direct_pa;
        writable = 1'b1;
      end
      default: begin
        if (!hit) begin
          fault  = 1'b1;
          refill = 1'b1;
          code   = store ? EXC_TLB_ST : EXC_TLB_LD;
        end else if (!valid) begin
          fault = 1'b1;
          code  = store ? EXC_TLB_ST : EXC_TLB_LD;
        end else if (store && !dirty) begin
          fault = 1'b1;
          code  = EXC_MODIFY;
        end else begin
          pa       = tlb_pa;
          writable = dirty;
        end
      end
    endcase
  end
endmodule

// File: rtl/vseg_capture.sv
module vseg_capture
  import vseg_pkg::*;
(
  input  logic          fault,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ctx_in,
  input  logic [AW-1:0] ehi_in,
  output logic [AW-1:0] badv_out,
  output logic [AW-1:0] ctx_out,
  output logic [AW-1:0] ehi_out
);
  localparam int unsigned VPN_W  = AW - PAGE_SHIFT;
  localparam int unsigned CTX_HI = CTX_LO + VPN_W;
  localparam int unsigned GAP_W  = PAGE_SHIFT - ASID_W;

  logic [AW-1:0] ctx_new;
  logic [AW-1:0] ehi_new;

  generate
    if (CTX_HI < AW) begin : g_ctx_top
      assign ctx_new = {ctx_in[AW-1:CTX_HI], addr[AW-1:PAGE_SHIFT], ctx_in[CTX_LO-1:0]};
    end else begin : g_ctx_full
      assign ctx_new = {addr[AW-1:PAGE_SHIFT], ctx_in[CTX_LO-1:0]};
    end
  endgenerate

  assign ehi_new = {addr[AW-1:PAGE_SHIFT], {GAP_W{1'b0}}, ehi_in[ASID_W-1:0]};

  always_comb begin
    if (fault) begin
      badv_out = addr;
      ctx_out  = ctx_new;
      ehi_out  = ehi_new;
    end else begin
      badv_out = '0;
      ctx_out  = ctx_in;
      ehi_out  = ehi_in;
    end
  end
endmodule

// File: rtl/vseg_fault_unit.sv
module vseg_fault_unit
  import vseg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_store,
  input  logic              req_user,
  input  logic              req_erl,
  input  logic              tlb_hit,
  input  logic              tlb_valid,
  input  logic              tlb_dirty,
  input  logic [AW-1:0]     tlb_pa,
  input  logic [AW-1:0]     cur_context,
  input  logic [AW-1:0]     cur_entryhi,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [CODE_W-1:0] rsp_code,
  output logic              rsp_refill,
  output logic [AW-1:0]     rsp_pa,
  output logic              rsp_writable,
  output logic [AW-1:0]     rsp_badvaddr,
  output logic [AW-1:0]     rsp_context,
  output logic [AW-1:0]     rsp_entryhi
);
  seg_kind_e         kind;
  logic [AW-1:0]     direct_pa;
  logic              c_fault;
  logic [CODE_W-1:0] c_code;
  logic              c_refill;
  logic [AW-1:0]     c_pa;
  logic              c_wr;
  logic [AW-1:0]     c_badv;
  logic [AW-1:0]     c_ctx;
  logic [AW-1:0]     c_ehi;
  logic              take;

  vseg_decode u_dec (
    .addr      (req_addr),
    .user      (req_user),
    .erl       (req_erl),
    .kind      (kind),
    .direct_pa (direct_pa)
  );

  vseg_classify u_cls (
    .kind      (kind),
    .direct_pa (direct_pa),
    .store     (req_store),
    .hit       (tlb_hit),
    .valid     (tlb_valid),
    .dirty     (tlb_dirty),
    .tlb_pa    (tlb_pa),
    .fault     (c_fault),
    .code      (c_code),
    .refill    (c_refill),
    .pa        (c_pa),
    .writable  (c_wr)
  );

  vseg_capture u_cap (
    .fault    (c_fault),
    .addr     (req_addr),
    .ctx_in   (cur_context),
    .ehi_in   (cur_entryhi),
    .badv_out (c_badv),
    .ctx_out  (c_ctx),
    .ehi_out  (c_ehi)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_code     <= EXC_NONE;
      rsp_refill   <= 1'b0;
      rsp_pa       <= '0;
      rsp_writable <= 1'b0;
      rsp_badvaddr <= '0;
      rsp_context  <= '0;
      rsp_entryhi  <= '0;
    end else if (take) begin
      rsp_valid    <= 1'b1;
      rsp_fault    <= c_fault;
      rsp_code     <= c_code;
      rsp_refill   <= c_refill;
      rsp_pa       <= c_pa;
      rsp_writable <= c_wr;
      rsp_badvaddr <= c_badv;
      rsp_context  <= c_ctx;
      rsp_entryhi  <= c_ehi;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vseg_fault_unit_chk.sv
module vseg_fault_unit_chk
  import vseg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [AW-1:0]     req_addr,
  input logic              req_store,
  input logic              req_user,
  input logic [AW-1:0]     cur_context,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_fault,
  input logic [CODE_W-1:0] rsp_code,
  input logic              rsp_refill,
  input logic [AW-1:0]     rsp_pa,
  input logic              rsp_writable,
  input logic [AW-1:0]     rsp_badvaddr,
  input logic [AW-1:0]     rsp_context
);
  // R1: user access to the kernel half is an address error
  a_r1_user_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_user && req_addr[AW-1]) |=>
      (rsp_fault && rsp_code == ($past(req_store) ? EXC_ADR_ST : EXC_ADR_LD) && !rsp_refill));

  // R7: the refill flag appears only with a TLB load or store code
  a_r7_refill_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_refill) |-> (rsp_fault && (rsp_code == EXC_TLB_LD || rsp_code == EXC_TLB_ST)));

  // R10: faulting address and preserved context bits
  a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (!rsp_fault || (rsp_badvaddr == $past(req_addr) && rsp_context[CTX_LO-1:0] == $past(cur_context[CTX_LO-1:0]))));

  // R11: a fault carries no translation
  a_r11_fault_no_pa: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && !rsp_writable && rsp_code != EXC_NONE));

  // R12: a stalled result holds
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_code) && $stable(rsp_pa) && $stable(rsp_badvaddr) && $stable(rsp_fault)));

  // R12: input ready follows the output port
  a_r12_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind vseg_fault_unit vseg_fault_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .req_store    (req_store),
  .req_user     (req_user),
  .cur_context  (cur_context),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_fault    (rsp_fault),
  .rsp_code     (rsp_code),
  .rsp_refill   (rsp_refill),
  .rsp_pa       (rsp_pa),
  .rsp_writable (rsp_writable),
  .rsp_badvaddr (rsp_badvaddr),
  .rsp_context  (rsp_context)
);

// File: tb/sim_vseg_fault_unit.sv
module sim_vseg_fault_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_store = 1'b0;
  logic        req_user = 1'b0;
  logic        req_erl = 1'b0;
  logic        tlb_hit = 1'b0;
  logic        tlb_valid = 1'b0;
  logic        tlb_dirty = 1'b0;
  logic [31:0] tlb_pa = '0;
  logic [31:0] cur_context = 32'hFFFF_FFFF;
  logic [31:0] cur_entryhi = 32'h1234_56AB;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_fault;
  logic [4:0]  rsp_code;
  logic        rsp_refill;
  logic [31:0] rsp_pa;
  logic        rsp_writable;
  logic [31:0] rsp_badvaddr;
  logic [31:0] rsp_context;
  logic [31:0] rsp_entryhi;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vseg_fault_unit u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input logic st, input logic usr, input logic erl,
                      input logic hit, input logic vld, input logic drt, input logic [31:0] tpa);
    @(negedge clk);
    req_addr = a; req_store = st; req_user = usr; req_erl = erl;
    tlb_hit = hit; tlb_valid = vld; tlb_dirty = drt; tlb_pa = tpa;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_ok(input string tag, input logic [31:0] pa, input logic wr);
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " fault"}, 32'(rsp_fault), 32'd0);
    chk({tag, " code"}, 32'(rsp_code), 32'd0);
    chk({tag, " pa"}, rsp_pa, pa);
    chk({tag, " wr"}, 32'(rsp_writable), 32'(wr));
    chk({tag, " badv"}, rsp_badvaddr, 32'd0);
    chk({tag, " ctx"}, rsp_context, cur_context);
    chk({tag, " ehi"}, rsp_entryhi, cur_entryhi);
  endtask

  task automatic expect_fault(input string tag, input logic [31:0] a, input logic [4:0] code,
                              input logic refill);
    chk({tag, " fault"}, 32'(rsp_fault), 32'd1);
    chk({tag, " code"}, 32'(rsp_code), 32'(code));
    chk({tag, " refill"}, 32'(rsp_refill), 32'(refill));
    chk({tag, " pa"}, rsp_pa, 32'd0);
    chk({tag, " wr"}, 32'(rsp_writable), 32'd0);
    chk({tag, " badv"}, rsp_badvaddr, a);
    chk({tag, " ctx"}, rsp_context, (cur_context & ~32'h007F_FFF0) | ((a >> 9) & 32'h007F_FFF0));
    chk({tag, " ehi"}, rsp_entryhi, (a & 32'hFFFF_E000) | (cur_entryhi & 32'hFF));
  endtask

  task automatic t_reset;
    chk("R12 reset valid", 32'(rsp_valid), 32'd0);
    chk("R12 reset ready", 32'(req_ready), 32'd1);
  endtask

  task automatic t_user_bad;
    send(32'h8000_1000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h5555_0000);
    expect_fault("R1 user load", 32'h8000_1000, 5'd4, 1'b0);
    send(32'hC123_4567, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
    expect_fault("R1 user store", 32'hC123_4567, 5'd5, 1'b0);
  endtask

  task automatic t_erl;
    send(32'h1234_5678, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hDEAD_0000);
    expect_ok("R2 erl", 32'h1234_5678, 1'b1);
  endtask

  task automatic t_useg_tlb;
    send(32'h0040_2000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0AB0_2000);
    expect_ok("R3 user hit clean load", 32'h0AB0_2000, 1'b0);
    send(32'h7FFF_F004, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0333_3004);
    expect_ok("R3 hit dirty store", 32'h0333_3004, 1'b1);
  endtask

  task automatic t_direct;
    send(32'h9FFF_FFFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    expect_ok("R4 kseg0", 32'h1FFF_FFFC, 1'b1);
    send(32'h8000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h7777_0000);
    expect_ok("R4 kseg0 base", 32'h0000_0000, 1'b1);
    send(32'hA010_0040, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    expect_ok("R5 kseg1", 32'h0010_0040, 1'b1);
    send(32'hBFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0);
    expect_ok("R5 kseg1 top", 32'h1FFF_FFFF, 1'b1);
  endtask

  task automatic t_mapped;
    send(32'hC000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0200_0000);
    expect_ok("R6 kseg2 hit", 32'h0200_0000, 1'b1);
    send(32'hFFFF_E123, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    expect_fault("R6 R7 kseg3 miss load", 32'hFFFF_E123, 5'd2, 1'b1);
  endtask

  task automatic t_tlb_faults;
    cur_context = 32'hA5A5_A5A5; cur_entryhi = 32'h0000_1F3C;
    send(32'h0000_3ABC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0);
    expect_fault("R7 miss store", 32'h0000_3ABC, 5'd3, 1'b1);
    send(32'h2468_ACE0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
    expect_fault("R8 invalid load", 32'h2468_ACE0, 5'd2, 1'b0);
    send(32'hD000_8000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
    expect_fault("R8 invalid store", 32'hD000_8000, 5'd3, 1'b0);
    send(32'h0123_4567, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0999_0000);
    expect_fault("R9 R10 modify user", 32'h0123_4567, 5'd1, 1'b0);
    send(32'hE765_4321, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0999_0000);
    expect_fault("R9 R10 modify kernel", 32'hE765_4321, 5'd1, 1'b0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    send(32'h0000_5000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
    expect_fault("R12 stalled miss", 32'h0000_5000, 5'd2, 1'b1);
    req_addr = 32'h8000_0040; req_store = 1'b0; req_user = 1'b0; req_erl = 1'b0;
    req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R12 ready low", 32'(req_ready), 32'd0);
      chk("R12 hold code", 32'(rsp_code), 32'd2);
      chk("R12 hold badv", rsp_badvaddr, 32'h0000_5000);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    expect_ok("R12 after release", 32'h0000_0040, 1'b1);
    @(negedge clk);
    chk("R12 drained", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_user_bad();
    t_erl();
    t_useg_tlb();
    t_direct();
    t_mapped();
    t_tlb_faults();
    t_backpressure();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule